// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two least significant address bits for four-beat bursts. A single qualified load pulse captures a full address. The two low bits become the start offset of the burst, and the upper bits are held in a register. Each later clock edge with the advance input high moves the burst to its next beat. The order of the beats comes from a static mode input. In linear order, the offset counts up and wraps modulo four. In interleaved order, the start offset is XORed with the beat number.

The surrounding logic decodes chip selects and strobe priority, then presents one load pulse. It keeps the mode input constant while the block runs; the mode may change only while reset is held. Both outputs come straight from registers, with only a small mapping step on the low bits, so they can feed an array address decoder directly.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state. From the next edge on, `low_out` reads 0 and `high_out` reads 0.
- R2: When `load` is high at a rising edge, `low_out` equals `addr_in[1:0]` after that edge, and the beat count restarts at zero.
- R3: When `load` and `advance` are both high at the same edge, the load wins. After that edge `low_out` equals `addr_in[1:0]`, with no step applied.
- R4: With `mode` = 0 (linear), after n advances since the last load, `low_out` = (start + n) mod 4.
- R5: With `mode` = 1 (interleaved), after n advances since the last load, `low_out` = start XOR (n mod 4).
- R6: When `load` and `advance` are both low at an edge, `low_out` and `high_out` keep their values.
- R7: After four advances, `low_out` returns to the loaded start value and the sequence continues. It never stops or saturates.
- R8: `high_out` takes `addr_in[ADDR_W-1:2]` at an edge where `load` is high, and is unchanged at every other edge outside reset.
- R9: `mode` is constant outside reset: 0 selects the linear order and 1 selects the interleaved order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | Order select: 0 linear, 1 interleaved; static outside reset |
| load | input | 1 | Qualified address capture pulse |
| advance | input | 1 | Step the burst one beat, active high |
| addr_in | input | ADDR_W | Address presented with `load` |
| low_out | output | 2 | Burst low address bits |
| high_out | output | ADDR_W-2 | Registered upper address bits |

## Verification
Load and advance can both be high at the same edge, and the load must win. The bench raises both together at chosen points in each burst, and also at random points in long mixed runs. At each of these edges, the reference model sets the expected low bits to the new start offset with no step added. The bench checks every edge in both orders. It covers all four start offsets and runs past the wrap point.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W   = 2;
    localparam int BEATS    = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        beat_t start;
        beat_t count;
    } burst_state_t;

    function automatic beat_t map_beat(order_e order, beat_t start, beat_t count);
        beat_t r;
        if (order == ORDER_INTERLEAVE) r = start ^ count;
        else                           r = start + count;
        return r;
    endfunction

endpackage

// File: rtl/burst_ctr_state.sv
module burst_ctr_state
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         advance,
    input  beat_t        start_in,
    output burst_state_t state
);

    burst_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q.start <= start_in;
            state_q.count <= '0;
        end else if (advance) begin
            state_q.count <= state_q.count + beat_t'(1);
        end
    end

    assign state = state_q;

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (load && advance) |=> (state_q.count == '0 && state_q.start == $past(start_in)));

    // R7
    count_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && state_q.count == beat_t'(BEATS-1)) |=> (state_q.count == '0));

    // R6
    count_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(state_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  order_e       order,
    input  burst_state_t state,
    output beat_t        low
);

    assign low = map_beat(order, state.start, state.count);

endmodule

// File: rtl/burst_hi_reg.sv
module burst_hi_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)       q_r <= '0;
        else if (load) q_r <= d;
    end

    assign q = q_r;

    // R8
    hi_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q_r == $past(d)));

    // R8
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q_r));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [1:0]        low_out,
    output logic [ADDR_W-3:0] high_out
);

    localparam int HI_W = ADDR_W - BEAT_W;

    order_e       order;
    burst_state_t state;
    beat_t        low_w;

    assign order = order_e'(mode);

    burst_ctr_state u_state (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .start_in (addr_in[BEAT_W-1:0]),
        .state    (state)
    );

    burst_order_map u_map (
        .order (order),
        .state (state),
        .low   (low_w)
    );

    burst_hi_reg #(.WIDTH(HI_W)) u_hi (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (addr_in[ADDR_W-1:BEAT_W]),
        .q    (high_out)
    );

    assign low_out = low_w;

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (low_out == $past(addr_in[BEAT_W-1:0])));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && !mode) |=> (low_out == $past(low_out) + 2'd1));

    // R5
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && mode) |=>
            ((low_out ^ $past(low_out)) == ($past(state.count) ^ ($past(state.count) + 2'd1))));

    // R6
    low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(low_out));

    // R9
    mode_static_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(mode));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (low_out == 2'd0 && high_out == '0));

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode = 1'b0;
    logic          load = 1'b0;
    logic          advance = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [1:0]    low_out;
    logic [AW-3:0] high_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int    m_start = 0;
    int    m_beats = 0;
    int    m_upper = 0;
    string low_tag = "R1";
    string hi_tag  = "R1";

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .load     (load),
        .advance  (advance),
        .addr_in  (addr_in),
        .low_out  (low_out),
        .high_out (high_out)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_start = 0; m_beats = 0; m_upper = 0;
            low_tag = "R1"; hi_tag = "R1";
        end else if (load) begin
            m_start = int'(addr_in) % 4;
            m_upper = int'(addr_in) / 4;
            m_beats = 0;
            low_tag = advance ? "R3" : "R2";
            hi_tag  = "R8";
        end else if (advance) begin
            m_beats = m_beats + 1;
            if (m_beats % 4 == 0) low_tag = "R7";
            else                  low_tag = mode ? "R5" : "R4";
            hi_tag = "R8";
        end else begin
            low_tag = "R6"; hi_tag = "R6";
        end
    end

    function automatic int exp_low();
        if (mode) return m_start ^ (m_beats % 4);
        return (m_start + m_beats) % 4;
    endfunction

    task automatic compare();
        total++;
        if (int'(low_out) != exp_low()) begin
            bad++;
            $display("FAIL %s low_out actual=%0d expected=%0d", low_tag, low_out, exp_low());
        end
        total++;
        if (int'(high_out) != m_upper) begin
            bad++;
            $display("FAIL %s high_out actual=%0h expected=%0h", hi_tag, high_out, m_upper);
        end
    endtask

    task automatic step(input logic ld, input logic adv, input logic [AW-1:0] a);
        @(negedge clk);
        compare();
        load = ld; advance = adv; addr_in = a;
    endtask

    task automatic burst_run(input int start);
        logic [AW-1:0] a;
        a = {16'(start * 16'h1357 + 16'h00A5), 2'(start)};
        step(1'b1, 1'b0, a);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '1);
        step(1'b0, 1'b0, '0);
        step(1'b1, 1'b1, a ^ 18'h2A5A7);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);
    endtask

    task automatic mixed_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0] == 4'd0, r[5:4] != 2'd0, AW'(r >> 8));
        end
    endtask

    task automatic restart(input logic m);
        @(negedge clk);
        rst = 1'b1; load = 1'b0; advance = 1'b0; mode = m;
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        @(negedge clk);
        compare();
        rst = 1'b0;
    endtask

    task automatic mode_probe(input logic m);
        step(1'b1, 1'b0, 18'h00001);
        step(1'b0, 1'b1, '0);
        @(negedge clk);
        total++;
        if (low_out != (m ? 2'd0 : 2'd2)) begin
            bad++;
            $display("FAIL R9 mode=%0b low_out actual=%0d expected=%0d",
                     m, low_out, m ? 0 : 2);
        end
        compare();
        load = 1'b0; advance = 1'b0;
    endtask

    initial begin
        restart(1'b0);
        for (int s = 0; s < 4; s++) burst_run(s);
        mode_probe(1'b0);
        mixed_run(300);
        restart(1'b1);
        for (int s = 0; s < 4; s++) burst_run(s);
        mode_probe(1'b1);
        mixed_run(300);
        step(1'b0, 1'b0, '0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule